// File: doc/BRIEF.md
# Iterative DES Cipher Core

This block runs one DES operation on a single 64-bit block under a 64-bit key word and shows the 64-bit answer on its output bus. A pin chooses between encryption and decryption. Both directions share one Feistel datapath and one key schedule. The core is iterative. One clock edge captures the inputs, applying the initial permutation and the 56-bit key selection. Each of the next sixteen edges runs one round. The final half swap and the inverse initial permutation are combinational at the output.

Each operation is started by reset. While the active-high reset is asserted, the surrounding logic places the block, the key and the mode on the inputs. It then releases reset. The first rising edge after the release captures all three, so the inputs are free to change from then on. The done flag rises after the seventeenth edge. Done and the result then hold until reset is asserted again. Key parity bits are never examined.

Bit numbering follows the cipher convention. Cipher bit 1 is the leftmost, most significant bit and maps to vector bit 63. Cipher bit 64 maps to vector bit 0.

The controller has three named states:

- ST_ARM is entered on reset. It performs the capture and moves to ST_ROUND on the next edge.
- ST_ROUND performs one round per edge. It stays in ST_ROUND until the sixteenth round and then moves to ST_DONE.
- ST_DONE asserts done and keeps the datapath frozen. It leaves ST_DONE only through reset.

Top module: `des_cipher_core`

## Requirements
- R1: With `encrypt` = 1, the key 133457799BBCDFF1 and the block 0123456789ABCDEF give 85E813540F0AB405. The key 0E329232EA6D0D73 and the block 8787878787878787 give 0000000000000000. An all-zero key and block give 8CA64DE9C1B123A7. An all-ones key and block give 7359B2163E4EDC58. Cipher bit 1 is `data_in[63]` / `key_in[63]` / `data_out[63]`.
- R2: With `encrypt` = 0, the block is decrypted. Each R1 ciphertext decrypts under its key back to the R1 plaintext.
- R3: The key parity bits are ignored. These are cipher bits 8, 16, ..., 64, i.e. vector bits 56, 48, 40, 32, 24, 16, 8 and 0. Flipping any of them leaves the result unchanged.
- R4: After reset is released, `done` stays low through the first 16 rising edges and is high after the 17th edge. At that point `data_out` holds the result.
- R5: Once `done` is high, `done` and `data_out` stay constant until reset is asserted again, whatever the inputs do.
- R6: The block, key and mode are sampled only at the first rising edge after reset is released. Changing any of them after that edge does not change the result.
- R7: Reset is asynchronous. Asserting it clears `done` without waiting for a clock edge, and each release starts a fresh operation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Asynchronous active-high reset; its release starts an operation |
| encrypt | input | 1 | 1 = encrypt, 0 = decrypt; sampled at the start edge |
| data_in | input | 64 | Input block, cipher bit 1 at bit 63 |
| key_in | input | 64 | Key word with parity bits in the low bit of each byte |
| data_out | output | 64 | Result, valid while done is high |
| done | output | 1 | High once the operation has completed |

## Verification
Encryption is tried with four known block and key pairs: a mixed block, a repeated-byte block, an all-zero case and an all-ones case. These separate a wrong permutation table, a wrong S-box row or a bit-order slip. Decryption of the same ciphertexts is used to separate a correct reversed key schedule from one with a shifted or missing rotation.

Three other kinds of pattern are also used:

- Keys whose parity bits are flipped must give unchanged results.
- The key, block and mode are scrambled after the first and after the second edge, to expose any use of live inputs instead of captured ones.
- Reset is raised in the middle of a cycle, to show that clearing does not wait for a clock.

// File: rtl/des_pkg.sv
`timescale 1ns/1ps
package des_pkg;

    localparam int BLK_W      = 64;
    localparam int HALF_W     = BLK_W / 2;
    localparam int KEY_W      = 64;
    localparam int CD_W       = 56;
    localparam int HALF_CD_W  = CD_W / 2;
    localparam int SUBKEY_W   = 48;
    localparam int NUM_ROUNDS = 16;
    localparam int RND_IDX_W  = $clog2(NUM_ROUNDS);
    localparam int NUM_SBOX   = 8;

    typedef enum logic [1:0] {
        ST_ARM,
        ST_ROUND,
        ST_DONE
    } des_state_e;

    // Round-function output permutation (cipher bit numbers).
    localparam int P_TBL [HALF_W] = '{
        16, 7, 20, 21, 29, 12, 28, 17, 1, 15, 23, 26, 5, 18, 31, 10,
        2, 8, 24, 14, 32, 27, 3, 9, 19, 13, 30, 6, 22, 11, 4, 25
    };

    // 56-bit key selection from the 64-bit key word.
    localparam int PC1_TBL [CD_W] = '{
        57, 49, 41, 33, 25, 17, 9, 1, 58, 50, 42, 34, 26, 18,
        10, 2, 59, 51, 43, 35, 27, 19, 11, 3, 60, 52, 44, 36,
        63, 55, 47, 39, 31, 23, 15, 7, 62, 54, 46, 38, 30, 22,
        14, 6, 61, 53, 45, 37, 29, 21, 13, 5, 28, 20, 12, 4
    };

    // 48-bit round key selection from the rotated halves.
    localparam int PC2_TBL [SUBKEY_W] = '{
        14, 17, 11, 24, 1, 5, 3, 28, 15, 6, 21, 10,
        23, 19, 12, 4, 26, 8, 16, 7, 27, 20, 13, 2,
        41, 52, 31, 37, 47, 55, 30, 40, 51, 45, 33, 48,
        44, 49, 39, 56, 34, 53, 46, 42, 50, 36, 29, 32
    };

    // One entry per box: 64 nibbles, indexed by row*16 + column, first entry in the top digit.
    localparam logic [255:0] SBOX_TBL [NUM_SBOX] = '{
        256'hE4D12FB83A6C5907_0F74E2D1A6CB9538_41E8D62BFC973A50_FC8249175B3EA06D,
        256'hF18E6B34972DC05A_3D47F28EC01A69B5_0E7BA4D158C6932F_D8A13F42B67C05E9,
        256'hA09E63F51DC7B428_D709346A285ECBF1_D6498F30B12C5AE7_1AD069874FE3B52C,
        256'h7DE3069A1285BC4F_D8B56F03472C1AE9_A690CB7DF13E5284_3F06A1D8945BC72E,
        256'h2C417AB6853FD0E9_EB2C47D150FA3986_421BAD78F9C5630E_B8C71E2D6F09A453,
        256'hC1AF92680D34E75B_AF427C9561DE0B38_9EF528C3704A1DB6_432C95FABE17608D,
        256'h4B2EF08D3C975A61_D0B7491AE35C2F86_14BDC37EAF680592_6BD814A7950FE23C,
        256'hD2846FB1A93E50C7_1FD8A374C56B0E92_7B419CE206ADF358_21E74A8DFC90356B
    };

    // Source cipher bit of initial-permutation output position i (0-based).
    function automatic int ip_src(input int i);
        int row;
        int col;
        int base;
        row  = i / 8;
        col  = i % 8;
        base = (row < 4) ? (58 + 2 * row) : (57 + 2 * (row - 4));
        return base - 8 * col;
    endfunction

    function automatic logic [BLK_W-1:0] apply_ip(input logic [BLK_W-1:0] x);
        logic [BLK_W-1:0] y;
        y = '0;
        for (int i = 0; i < BLK_W; i++) y[BLK_W-1-i] = x[BLK_W-ip_src(i)];
        return y;
    endfunction

    function automatic logic [BLK_W-1:0] apply_fp(input logic [BLK_W-1:0] x);
        logic [BLK_W-1:0] y;
        y = '0;
        for (int i = 0; i < BLK_W; i++) y[BLK_W-ip_src(i)] = x[BLK_W-1-i];
        return y;
    endfunction

    function automatic logic [SUBKEY_W-1:0] expand(input logic [HALF_W-1:0] r);
        logic [SUBKEY_W-1:0] y;
        int src;
        y = '0;
        for (int i = 0; i < SUBKEY_W; i++) begin
            src = ((4 * (i / 6) + (i % 6) + HALF_W - 1) % HALF_W) + 1;
            y[SUBKEY_W-1-i] = r[HALF_W-src];
        end
        return y;
    endfunction

    function automatic logic [HALF_W-1:0] sbox_layer(input logic [SUBKEY_W-1:0] x);
        logic [HALF_W-1:0] y;
        logic [5:0]        six;
        logic [5:0]        idx;
        y = '0;
        for (int g = 0; g < NUM_SBOX; g++) begin
            six = x[SUBKEY_W-1-6*g -: 6];
            idx = {six[5], six[0], six[4:1]};
            y[HALF_W-1-4*g -: 4] = SBOX_TBL[g][255-4*int'(idx) -: 4];
        end
        return y;
    endfunction

    function automatic logic [HALF_W-1:0] pbox(input logic [HALF_W-1:0] x);
        logic [HALF_W-1:0] y;
        y = '0;
        for (int i = 0; i < HALF_W; i++) y[HALF_W-1-i] = x[HALF_W-P_TBL[i]];
        return y;
    endfunction

    function automatic logic [HALF_W-1:0] round_fn(input logic [HALF_W-1:0] r,
                                                   input logic [SUBKEY_W-1:0] k);
        return pbox(sbox_layer(expand(r) ^ k));
    endfunction

    function automatic logic [CD_W-1:0] select_pc1(input logic [KEY_W-1:0] k);
        logic [CD_W-1:0] y;
        y = '0;
        for (int i = 0; i < CD_W; i++) y[CD_W-1-i] = k[KEY_W-PC1_TBL[i]];
        return y;
    endfunction

    function automatic logic [SUBKEY_W-1:0] select_pc2(input logic [CD_W-1:0] cd);
        logic [SUBKEY_W-1:0] y;
        y = '0;
        for (int i = 0; i < SUBKEY_W; i++) y[SUBKEY_W-1-i] = cd[CD_W-PC2_TBL[i]];
        return y;
    endfunction

    // Rotation amount of the standard schedule at 0-based step pos.
    function automatic logic [1:0] sched_step(input int pos);
        return (pos == 0 || pos == 1 || pos == 8 || pos == 15) ? 2'd1 : 2'd2;
    endfunction

    function automatic logic [CD_W-1:0] rotate_halves(input logic [CD_W-1:0] cd,
                                                      input logic [1:0]      amt,
                                                      input logic            to_left);
        logic [HALF_CD_W-1:0] c;
        logic [HALF_CD_W-1:0] d;
        c = cd[CD_W-1:HALF_CD_W];
        d = cd[HALF_CD_W-1:0];
        for (int s = 0; s < 2; s++) begin
            if (s < int'(amt)) begin
                if (to_left) begin
                    c = {c[HALF_CD_W-2:0], c[HALF_CD_W-1]};
                    d = {d[HALF_CD_W-2:0], d[HALF_CD_W-1]};
                end else begin
                    c = {c[0], c[HALF_CD_W-1:1]};
                    d = {d[0], d[HALF_CD_W-1:1]};
                end
            end
        end
        return {c, d};
    endfunction

endpackage

// File: rtl/des_seq_ctrl.sv
`timescale 1ns/1ps
module des_seq_ctrl
    import des_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 encrypt,
    output logic                 load_en,
    output logic                 round_en,
    output logic [RND_IDX_W-1:0] round_idx,
    output logic                 dec_mode,
    output logic                 done
);

    localparam logic [RND_IDX_W-1:0] LAST_IDX = RND_IDX_W'(NUM_ROUNDS - 1);

    des_state_e           state_q;
    des_state_e           state_nx;
    logic [RND_IDX_W-1:0] cnt_q;
    logic                 dec_q;

    // State register.
    always_ff @(posedge clk or posedge rst) begin
        if (rst) state_q <= ST_ARM;
        else     state_q <= state_nx;
    end

    // Round counter and captured mode.
    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            cnt_q <= '0;
            dec_q <= 1'b0;
        end else begin
            if (state_q == ST_ARM)   dec_q <= ~encrypt;
            if (state_q == ST_ROUND) cnt_q <= cnt_q + 1'b1;
        end
    end

    // Transitions.
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_ARM:   state_nx = ST_ROUND;
            ST_ROUND: state_nx = (cnt_q == LAST_IDX) ? ST_DONE : ST_ROUND;
            ST_DONE:  state_nx = ST_DONE;
            default:  state_nx = ST_ARM;
        endcase
    end

    // Outputs.
    always_comb begin
        load_en  = 1'b0;
        round_en = 1'b0;
        done     = 1'b0;
        unique case (state_q)
            ST_ARM:   load_en  = 1'b1;
            ST_ROUND: round_en = 1'b1;
            ST_DONE:  done     = 1'b1;
            default:  load_en  = 1'b0;
        endcase
    end

    assign round_idx = cnt_q;
    assign dec_mode  = dec_q;

endmodule

// File: rtl/des_key_path.sv
`timescale 1ns/1ps
module des_key_path
    import des_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 load_en,
    input  logic                 round_en,
    input  logic [RND_IDX_W-1:0] round_idx,
    input  logic                 dec_mode,
    input  logic [KEY_W-1:0]     key_in,
    output logic [SUBKEY_W-1:0]  subkey
);

    logic [CD_W-1:0] cd_q;
    logic [CD_W-1:0] cd_rot;
    logic [1:0]      rot_amt;

    // Encryption walks the schedule forward rotating left. Decryption starts
    // from the fully rotated halves (equal to the loaded ones) and walks back.
    always_comb begin
        if (dec_mode) begin
            rot_amt = (round_idx == '0) ? 2'd0
                                        : sched_step(NUM_ROUNDS - int'(round_idx));
        end else begin
            rot_amt = sched_step(int'(round_idx));
        end
        cd_rot = rotate_halves(cd_q, rot_amt, ~dec_mode);
        subkey = select_pc2(cd_rot);
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst)           cd_q <= '0;
        else if (load_en)  cd_q <= select_pc1(key_in);
        else if (round_en) cd_q <= cd_rot;
    end

endmodule

// File: rtl/des_feistel_path.sv
`timescale 1ns/1ps
module des_feistel_path
    import des_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                load_en,
    input  logic                round_en,
    input  logic [BLK_W-1:0]    blk_in,
    input  logic [SUBKEY_W-1:0] subkey,
    output logic [BLK_W-1:0]    blk_out
);

    logic [HALF_W-1:0] left_q;
    logic [HALF_W-1:0] right_q;
    logic [BLK_W-1:0]  permuted;

    assign permuted = apply_ip(blk_in);

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            left_q  <= '0;
            right_q <= '0;
        end else if (load_en) begin
            left_q  <= permuted[BLK_W-1:HALF_W];
            right_q <= permuted[HALF_W-1:0];
        end else if (round_en) begin
            left_q  <= right_q;
            right_q <= left_q ^ round_fn(right_q, subkey);
        end
    end

    // Undo the last swap, then the inverse initial permutation.
    assign blk_out = apply_fp({right_q, left_q});

endmodule

// File: rtl/des_cipher_core.sv
`timescale 1ns/1ps
module des_cipher_core
    import des_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             encrypt,
    input  logic [BLK_W-1:0] data_in,
    input  logic [KEY_W-1:0] key_in,
    output logic [BLK_W-1:0] data_out,
    output logic             done
);

    logic                 load_en;
    logic                 round_en;
    logic [RND_IDX_W-1:0] round_idx;
    logic                 dec_mode;
    logic [SUBKEY_W-1:0]  subkey;

    des_seq_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .encrypt   (encrypt),
        .load_en   (load_en),
        .round_en  (round_en),
        .round_idx (round_idx),
        .dec_mode  (dec_mode),
        .done      (done)
    );

    des_key_path u_keys (
        .clk       (clk),
        .rst       (rst),
        .load_en   (load_en),
        .round_en  (round_en),
        .round_idx (round_idx),
        .dec_mode  (dec_mode),
        .key_in    (key_in),
        .subkey    (subkey)
    );

    des_feistel_path u_data (
        .clk       (clk),
        .rst       (rst),
        .load_en   (load_en),
        .round_en  (round_en),
        .blk_in    (data_in),
        .subkey    (subkey),
        .blk_out   (data_out)
    );

endmodule

// File: rtl/des_cipher_core_chk.sv
`timescale 1ns/1ps
module des_cipher_core_chk
    import des_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             done,
    input logic [BLK_W-1:0] data_out
);

    localparam int          LATENCY = NUM_ROUNDS + 1;
    localparam int          CNT_W   = $clog2(LATENCY + 2);
    localparam logic [CNT_W-1:0] LAT_C = CNT_W'(LATENCY);

    // Edges seen since reset was released, saturating past the latency.
    logic [CNT_W-1:0] edge_cnt;

    always_ff @(posedge clk or posedge rst) begin
        if (rst)                  edge_cnt <= '0;
        else if (edge_cnt <= LAT_C) edge_cnt <= edge_cnt + 1'b1;
    end

    assert_done_latency_R4: assert property (@(posedge clk) disable iff (rst)
        done == (edge_cnt >= LAT_C));

    assert_done_hold_R5: assert property (@(posedge clk) disable iff (rst)
        done |=> done);

    assert_result_hold_R5: assert property (@(posedge clk) disable iff (rst)
        done |=> $stable(data_out));

    assert_result_known_R1: assert property (@(posedge clk) disable iff (rst)
        done |-> !$isunknown(data_out));

endmodule

bind des_cipher_core des_cipher_core_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .done     (done),
    .data_out (data_out)
);

// File: tb/des_cipher_core_tb.sv
`timescale 1ns/1ps
module des_cipher_core_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        encrypt = 1'b1;
    logic [63:0] data_in = '0;
    logic [63:0] key_in = '0;
    logic [63:0] data_out;
    logic        done;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    des_cipher_core u_dut (
        .clk      (clk),
        .rst      (rst),
        .encrypt  (encrypt),
        .data_in  (data_in),
        .key_in   (key_in),
        .data_out (data_out),
        .done     (done)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One complete operation. scramble_at > 0 garbles all inputs after that edge.
    task automatic run_op(input logic [63:0] k, input logic [63:0] blk, input logic enc,
                          input int scramble_at, input logic [63:0] exp, input string req);
        @(negedge clk);
        rst = 1'b1; data_in = blk; key_in = k; encrypt = enc;
        @(negedge clk);
        rst = 1'b0;
        for (int e = 1; e <= 17; e++) begin
            @(posedge clk);
            @(negedge clk);
            if (e == scramble_at) begin
                data_in = ~blk ^ 64'h5A5A_5A5A_A5A5_A5A5;
                key_in  = k ^ 64'h0F0F_0F0F_F0F0_F0F0;
                encrypt = ~enc;
            end
            if (e == 16) check(done == 1'b0, "R4 done early", 64'(done), 64'd0);
        end
        check(done == 1'b1, "R4 done after 17 edges", 64'(done), 64'd1);
        check(data_out == exp, req, data_out, exp);
    endtask

    task automatic t_reset_state;
        repeat (3) @(negedge clk);
        check(done == 1'b0, "R7 done low in reset", 64'(done), 64'd0);
    endtask

    task automatic t_encrypt_vectors;
        run_op(64'h1334_5779_9BBC_DFF1, 64'h0123_4567_89AB_CDEF, 1'b1, 0,
               64'h85E8_1354_0F0A_B405, "R1 enc mixed");
        run_op(64'h0E32_9232_EA6D_0D73, 64'h8787_8787_8787_8787, 1'b1, 0,
               64'h0, "R1 enc repeated byte");
        run_op(64'h0, 64'h0, 1'b1, 0, 64'h8CA6_4DE9_C1B1_23A7, "R1 enc zeros");
        run_op('1, '1, 1'b1, 0, 64'h7359_B216_3E4E_DC58, "R1 enc ones");
    endtask

    task automatic t_decrypt_vectors;
        run_op(64'h1334_5779_9BBC_DFF1, 64'h85E8_1354_0F0A_B405, 1'b0, 0,
               64'h0123_4567_89AB_CDEF, "R2 dec mixed");
        run_op(64'h0E32_9232_EA6D_0D73, 64'h0, 1'b0, 0,
               64'h8787_8787_8787_8787, "R2 dec repeated byte");
        run_op(64'h0, 64'h8CA6_4DE9_C1B1_23A7, 1'b0, 0, 64'h0, "R2 dec zeros");
    endtask

    task automatic t_parity_ignored;
        run_op(64'h0101_0101_0101_0101, 64'h0, 1'b1, 0,
               64'h8CA6_4DE9_C1B1_23A7, "R3 parity set enc");
        run_op(64'h1235_5678_9ABD_DEF0, 64'h0123_4567_89AB_CDEF, 1'b1, 0,
               64'h85E8_1354_0F0A_B405, "R3 parity flipped enc");
        run_op(64'hFEFE_FEFE_FEFE_FEFE, 64'h7359_B216_3E4E_DC58, 1'b0, 0,
               '1, "R3 parity cleared dec");
    endtask

    task automatic t_input_capture;
        run_op(64'h1334_5779_9BBC_DFF1, 64'h0123_4567_89AB_CDEF, 1'b1, 1,
               64'h85E8_1354_0F0A_B405, "R6 change after edge 1 enc");
        run_op(64'h1334_5779_9BBC_DFF1, 64'h85E8_1354_0F0A_B405, 1'b0, 2,
               64'h0123_4567_89AB_CDEF, "R6 change after edge 2 dec");
    endtask

    task automatic t_hold;
        logic [63:0] res;
        run_op(64'h0E32_9232_EA6D_0D73, 64'h8787_8787_8787_8787, 1'b1, 0,
               64'h0, "R1 enc before hold");
        res = data_out;
        for (int c = 0; c < 40; c++) begin
            @(negedge clk);
            data_in = data_in + 64'h1111;
            key_in  = key_in ^ 64'h0200_0000_0000_0002;
            encrypt = ~encrypt;
        end
        check(done == 1'b1, "R5 done held", 64'(done), 64'd1);
        check(data_out == res, "R5 result held", data_out, res);
    endtask

    task automatic t_async_reset;
        @(negedge clk);
        #3;
        rst = 1'b1;
        #1;
        check(done == 1'b0, "R7 async clear", 64'(done), 64'd0);
        run_op(64'h0, 64'h0, 1'b1, 0, 64'h8CA6_4DE9_C1B1_23A7, "R7 fresh op");
    endtask

    initial begin
        t_reset_state();
        t_encrypt_vectors();
        t_decrypt_vectors();
        t_parity_ignored();
        t_input_capture();
        t_hold();
        t_async_reset();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(20 * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=%0d expected=0", 1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule